// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-mapped watchdog. Software programs a 16-bit reload value and a two-stage timebase, then starts a down counter. The timebase divides the input clock first by a programmable prescale of P+1 (P is 8 bits), then by a power-of-two stage of 16, 32, 64 or 128. Software keeps the system alive by writing the live count register before it expires.

When the counter expires it reloads itself from the reload register. Depending on two control bits, it can also latch a sticky interrupt, start a fixed-length reset request pulse, or do both. A separate write-only word clears the interrupt. Clearing the run bit freezes the count. Clearing the reset-enable bit cuts off any reset request at once.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0, the reload and live count registers read 0x8000, the clear word (offset 0x0C) reads 0, and both irqOut and resetReq are low.
- R2: The control word at offset 0x00 holds reset-enable in bit 0, interrupt-enable in bit 2, run in bit 5, divider select in bits 4:3 and prescale P in bits 15:8. Every other bit reads back as 0, so writing all ones reads back 0x0000FF3D.
- R3: While running, one count tick occurs every (P+1)·16·2^sel input clock cycles, where sel is the divider select code 0..3.
- R4: On each tick the count drops by one. A tick that finds the count at 0 is an expiry: the count reloads from the reload register. A count started at N therefore expires on tick N+1.
- R5: A write to offset 0x08 loads the live count in that same cycle, overriding any tick, and this restarts the time to expiry.
- R6: An expiry with bit 2 set raises irqOut, which stays high until any write to offset 0x0C. With bit 2 clear an expiry leaves irqOut low.
- R7: An expiry with bit 0 set drives resetReq high for exactly 16 input clock cycles.
- R8: With bit 5 clear the count holds its value. A control write that clears bit 0 forces resetReq low from the cycle it takes effect, and it stays low while the bit is clear.
- R9: Both timebase stages clear while bit 5 is 0, so the first tick after starting comes a full tick period after the enabling write.
- R10: The reload register at offset 0x04 takes the low 16 bits of a write and reads back zero-extended. Writing it does not change the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the timebase |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte address of the register word |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Sticky expiry interrupt |
| resetReq | output | 1 | Reset request pulse |

## Verification
The embedded properties check the following on every cycle:
- a count write lands on the next edge;
- a non-expiring tick steps the count down by one, and an expiry reloads it;
- a stopped counter holds still;
- the interrupt stays set until a clear write;
- resetReq never shows while reset-enable is low, and every pulse begins fully loaded.

Only the bench scenarios can show the absolute expiry times for each prescale and divider combination, the 16-cycle pulse width, the postponed expiry after a service write, the full-period first tick after a restart, and the readback values of each register.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 8;
  localparam int SEL_W   = 2;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1) << (CNT_W - 1);

  // Control bit positions (decoded by software, kept fixed)
  localparam int B_RSTEN = 0;
  localparam int B_INTEN = 2;
  localparam int B_SEL   = 3;
  localparam int B_RUN   = 5;
  localparam int B_PRE   = 8;

  // Word indices of the register map
  localparam int W_CTRL  = 0;
  localparam int W_DATA  = 1;
  localparam int W_COUNT = 2;
  localparam int W_CLEAR = 3;

  typedef struct packed {
    logic              cntLoad;
    logic              datLoad;
    logic [CNT_W-1:0]  wrVal;
    logic              run;
    logic [SEL_W-1:0]  divSel;
    logic [PRE_W-1:0]  preVal;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
`timescale 1ns/1ps
module wdog_datapath import wdog_pkg::*; #(
  parameter int DIV_BASE_LOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strb,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] dataVal,
  output logic             expire
);
  localparam int DIV_W = DIV_BASE_LOG + (1 << SEL_W) - 1;
  localparam logic [SEL_W-1:0] SEL_TOP = {SEL_W{1'b1}};

  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMax;
  logic             preTick;
  logic             tick;

  // Largest divider code gives the full-width all-ones terminal count
  always_comb begin
    divMax  = {DIV_W{1'b1}} >> (SEL_TOP - strb.divSel);
    preTick = strb.run && (preCnt >= strb.preVal);
    tick    = preTick && (divCnt >= divMax);
    expire  = tick && (countVal == '0) && !strb.cntLoad;
  end

  // Prescaler stage: clears while stopped (R9)
  always_ff @(posedge clk) begin
    if (!rstN)           preCnt <= '0;
    else if (!strb.run)  preCnt <= '0;
    else if (preTick)    preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  // Power-of-two stage (R3)
  always_ff @(posedge clk) begin
    if (!rstN)           divCnt <= '0;
    else if (!strb.run)  divCnt <= '0;
    else if (tick)       divCnt <= '0;
    else if (preTick)    divCnt <= divCnt + 1'b1;
  end

  // Live counter (R4, R5)
  always_ff @(posedge clk) begin
    if (!rstN)                 countVal <= CNT_RST;
    else if (strb.cntLoad)     countVal <= strb.wrVal;
    else if (tick) begin
      if (countVal == '0)      countVal <= dataVal;
      else                     countVal <= countVal - 1'b1;
    end
  end

  // Reload register (R10)
  always_ff @(posedge clk) begin
    if (!rstN)                 dataVal <= CNT_RST;
    else if (strb.datLoad)     dataVal <= strb.wrVal;
  end

  p_load_now_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> countVal == $past(strb.wrVal));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countVal != '0 && !strb.cntLoad) |=> countVal == $past(countVal) - 1'b1);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> countVal == $past(dataVal));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.cntLoad) |=> $stable(countVal));
endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl import wdog_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  dataVal,
  input  logic              expire,
  output wdStrobe_t         strb,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              resetReq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int PW    = $clog2(PULSE_LEN + 1);

  logic [IDX_W-1:0] wordIdx;
  logic             wrCtrl, wrData, wrCount, wrClear;
  logic             rstEn, intEn, run;
  logic [SEL_W-1:0] divSel;
  logic [PRE_W-1:0] preVal;
  logic             rstEnNext;
  logic             irqFlag;
  logic [PW-1:0]    pulseCnt;
  logic             unusedBits;

  assign unusedBits = ^{regWrData, regAddr};

  always_comb begin
    wordIdx   = regAddr[ADDR_W-1:2];
    wrCtrl    = regWrEn && (wordIdx == IDX_W'(W_CTRL));
    wrData    = regWrEn && (wordIdx == IDX_W'(W_DATA));
    wrCount   = regWrEn && (wordIdx == IDX_W'(W_COUNT));
    wrClear   = regWrEn && (wordIdx == IDX_W'(W_CLEAR));
    rstEnNext = wrCtrl ? regWrData[B_RSTEN] : rstEn;
  end

  always_comb begin
    strb.cntLoad = wrCount;
    strb.datLoad = wrData;
    strb.wrVal   = regWrData[CNT_W-1:0];
    strb.run     = run;
    strb.divSel  = divSel;
    strb.preVal  = preVal;
  end

  // Control word (R2)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstEn  <= 1'b0;
      intEn  <= 1'b0;
      run    <= 1'b0;
      divSel <= '0;
      preVal <= '0;
    end else if (wrCtrl) begin
      rstEn  <= regWrData[B_RSTEN];
      intEn  <= regWrData[B_INTEN];
      run    <= regWrData[B_RUN];
      divSel <= regWrData[B_SEL +: SEL_W];
      preVal <= regWrData[B_PRE +: PRE_W];
    end
  end

  // Sticky interrupt; a new expiry wins over a clear (R6)
  always_ff @(posedge clk) begin
    if (!rstN)                 irqFlag <= 1'b0;
    else if (expire && intEn)  irqFlag <= 1'b1;
    else if (wrClear)          irqFlag <= 1'b0;
  end

  // Reset request pulse (R7, R8)
  always_ff @(posedge clk) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (!rstEnNext)       pulseCnt <= '0;
    else if (expire && rstEn)  pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign irqOut   = irqFlag;
  assign resetReq = (pulseCnt != '0);

  // Read mux; the clear word reads as zero
  always_comb begin
    regRdData = '0;
    case (wordIdx)
      IDX_W'(W_CTRL):  regRdData = DATA_W'({preVal, 2'b00, run, divSel, intEn, 1'b0, rstEn});
      IDX_W'(W_DATA):  regRdData = DATA_W'(dataVal);
      IDX_W'(W_COUNT): regRdData = DATA_W'(countVal);
      default:         regRdData = '0;
    endcase
  end

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !wrClear) |=> irqOut);

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(intEn));

  p_rst_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rstEn |-> !resetReq);

  p_pulse_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> pulseCnt == PW'(PULSE_LEN));
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer import wdog_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              resetReq
);
  wdStrobe_t        strb;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] dataVal;
  logic             expire;

  wdog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .countVal(countVal), .dataVal(dataVal), .expire(expire),
    .strb(strb), .regRdData(regRdData),
    .irqOut(irqOut), .resetReq(resetReq)
  );

  wdog_datapath #(
    .DIV_BASE_LOG(4)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .countVal(countVal), .dataVal(dataVal), .expire(expire)
  );
endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  logic        resetReq;

  int totalCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .resetReq(resetReq)
  );

  // Vectors: prescale, divider code, start count, cycles to expiry
  localparam int NV = 6;
  localparam int vP[NV] = '{0, 1, 0, 2, 0, 3};
  localparam int vS[NV] = '{0, 0, 1, 2, 3, 1};
  localparam int vN[NV] = '{2, 1, 3, 0, 1, 2};
  localparam int vK[NV] = '{48, 64, 128, 192, 256, 384};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < 5000) begin @(negedge clk); n++; end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++; totalCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    int n, m;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(4'h0, rd); check(rd == 32'h0, "R1 ctrl", rd, 32'h0);
    readReg(4'h4, rd); check(rd == 32'h8000, "R1 data", rd, 32'h8000);
    readReg(4'h8, rd); check(rd == 32'h8000, "R1 count", rd, 32'h8000);
    readReg(4'hC, rd); check(rd == 32'h0, "R1 clear word", rd, 32'h0);
    check(!irqOut && !resetReq, "R1 outputs", {irqOut, resetReq}, 0);

    // R2 control layout
    writeReg(4'h0, 32'hFFFF_FFFF);
    readReg(4'h0, rd); check(rd == 32'h0000_FF3D, "R2 readback", rd, 32'h0000_FF3D);
    writeReg(4'h0, 32'h0);

    // R10 reload register width, count untouched
    writeReg(4'h4, 32'hABCD_1234);
    readReg(4'h4, rd); check(rd == 32'h1234, "R10 data", rd, 32'h1234);
    readReg(4'h8, rd); check(rd == 32'h8000, "R10 count untouched", rd, 32'h8000);

    // R3 R4 R6 timebase vectors
    for (int i = 0; i < NV; i++) begin
      writeReg(4'h4, vN[i]);
      writeReg(4'h8, vN[i]);
      writeReg(4'h0, (vP[i] << 8) | (vS[i] << 3) | 32'h24);
      regAddr = 4'h8;
      waitIrq(n);
      check(n == vK[i], "R3 expiry time", n, vK[i]);
      readReg(4'h8, rd); check(rd == vN[i], "R4 reload", rd, vN[i]);
      writeReg(4'h0, 32'h0);
      repeat (3) @(negedge clk);
      check(irqOut, "R6 sticky", irqOut, 1);
      writeReg(4'hC, 32'hDEAD_BEEF);
      check(!irqOut, "R6 clear", irqOut, 0);
    end

    // R5 service write postpones expiry
    writeReg(4'h4, 3);
    writeReg(4'h8, 3);
    writeReg(4'h0, 32'h24);
    repeat (40) @(negedge clk);
    writeReg(4'h8, 3);
    waitIrq(n);
    check(n == 54, "R5 serviced expiry", n, 54);
    writeReg(4'h0, 32'h0);
    writeReg(4'hC, 32'h0);

    // R9 timebase restarts on enable
    writeReg(4'h4, 5);
    writeReg(4'h8, 5);
    writeReg(4'h0, 32'h20);
    repeat (10) @(negedge clk);
    writeReg(4'h0, 32'h0);
    writeReg(4'h0, 32'h20);
    n = 0; readReg(4'h8, rd);
    while (rd == 5 && n < 5000) begin @(negedge clk); n++; readReg(4'h8, rd); end
    check(n == 16, "R9 first tick", n, 16);
    check(rd == 4, "R9 count after tick", rd, 4);
    writeReg(4'h0, 32'h0);

    // R8 frozen count
    readReg(4'h8, rd);
    repeat (100) @(negedge clk);
    readReg(4'h8, rd2); check(rd2 == rd, "R8 frozen", rd2, rd);

    // R7 pulse width, interrupt disabled
    writeReg(4'h4, 1);
    writeReg(4'h8, 0);
    writeReg(4'h0, 32'h21);
    n = 0;
    while (!resetReq && n < 5000) begin @(negedge clk); n++; end
    check(n == 16, "R7 pulse start", n, 16);
    m = 0;
    while (resetReq && m < 5000) begin @(negedge clk); m++; end
    check(m == 16, "R7 pulse width", m, 16);
    check(!irqOut, "R6 no irq without enable", irqOut, 0);

    // R8 clearing reset enable cuts the pulse
    n = 0;
    while (!resetReq && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    writeReg(4'h0, 32'h0);
    check(!resetReq, "R8 pulse cut", resetReq, 0);
    n = 0;
    repeat (100) begin @(negedge clk); if (resetReq) n++; end
    check(n == 0, "R8 stays low", n, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule